// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block buffers 18-bit words between a producer clocked by `wr_clk` and a consumer clocked by `rd_clk`. The two clocks run freely. They may be unrelated or they may be the same net. The storage array has 512 locations. The oldest word always sits in an output register, and `out_rdy` marks it as valid. A consumer therefore sees data as soon as the first word has crossed into its domain, without issuing a read first. On the write side, a word is accepted only when two enables of opposite polarity agree and `in_rdy` is high. On the read side, three active-low qualifiers must all be low before a word is consumed.

A write-domain state machine has three states. `W_RESET` holds `in_rdy` low while the write-side reset synchronizer is active. `W_PROG` follows reset release, and in it a write with `thr_load` high sets the almost-full/almost-empty threshold N instead of storing data. `W_RUN` is entered on the first stored data word, and it lasts until the next reset. Its transitions are:
- W_RESET→W_PROG when the reset synchronizer releases.
- W_PROG→W_PROG on a threshold load.
- W_PROG→W_RUN on the first data write.

A read-domain state machine also has three states: `R_RESET`, `R_EMPTY` (output register invalid) and `R_VALID` (output register holds the oldest word). Its transitions are:
- R_RESET→R_EMPTY on synchronizer release.
- R_EMPTY→R_VALID, the fall-through load, whenever the array holds a word.
- R_VALID→R_VALID on a read that refills the register from the array.
- R_VALID→R_EMPTY on a read that takes the last word.

Pointers cross between the domains as Gray codes through two-flop synchronizers. The half-full flag and the combined almost-full/almost-empty flag are registered in the read domain. They count the word held in the output register.

Top module: `dcfifo_fwft`

## Requirements
- R1: At most 512 words are held, counting the output register. With no reads, exactly 512 writes are accepted, and `in_rdy` is then low.
- R2: A word is stored on a `wr_clk` rising edge only when `wr_en_hi`=1, `wr_en_lo_n`=0 and `in_rdy`=1. Any other combination stores nothing.
- R3: A word is consumed on a `rd_clk` rising edge only when `rd_en_n`, `oe_a_n` and `oe_b_n` are all 0 and `out_rdy`=1. Otherwise `dout` holds its value.
- R4: The first word written into an empty FIFO reaches `dout`, with `out_rdy` high, whatever the levels of the read qualifiers.
- R5: While `out_rdy` is high, `dout` is the oldest unread word. `out_rdy` is never high with nothing stored, and it falls after the last word is read.
- R6: `rst_n` low resets the block asynchronously. While it is low, `in_rdy`=0, `out_rdy`=0, `half_full`=0 and `almost_fe`=1.
- R7: After `rst_n` rises, `in_rdy` stays low for at least the next two `wr_clk` edges while the write-side reset synchronizer is active, and writes made then are ignored.
- R8: `half_full` is 1 while the stored count is 257 or more, and 0 otherwise.
- R9: `almost_fe` is 1 while the count is at most N or at least 512−N. N is 64 after reset unless it is programmed.
- R10: In `W_PROG`, an accepted write with `thr_load`=1 sets N to `din[8:0]` and stores nothing. After the first data word, `thr_load` has no effect and such a write stores `din` as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_hi | input | 1 | Write enable, active high |
| wr_en_lo_n | input | 1 | Write enable, active low |
| thr_load | input | 1 | Selects threshold programming for a write in `W_PROG` |
| din | input | 18 | Write data; bits 8:0 carry N when programming |
| in_rdy | output | 1 | Space available, write-clock timed |
| rd_en_n | input | 1 | Read enable, active low |
| oe_a_n | input | 1 | Read qualifier A, active low |
| oe_b_n | input | 1 | Read qualifier B, active low |
| dout | output | 18 | Oldest word, from the output register |
| out_rdy | output | 1 | `dout` valid, read-clock timed |
| half_full | output | 1 | Count is 257 or more |
| almost_fe | output | 1 | Count is at most N or at least 512−N |

## Verification
The assertions assume that `rst_n` is held low for several edges of both clocks, which lets every synchronizer stage clear. They also assume that the threshold changes only while the FIFO is empty, so the read domain can use it without synchronization. The stimulus keeps reset low for six cycles, both at start-up and in the middle of the run. It issues threshold loads only in the programming window that directly follows reset. Both clocks are driven from one source, which makes the flag latency repeatable. Flag checks are taken only after at least eight idle cycles, because each pointer needs several cycles to cross into the other domain.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    // Write-domain control states
    typedef enum logic [1:0] {
        W_RESET = 2'd0,
        W_PROG  = 2'd1,
        W_RUN   = 2'd2
    } wr_state_t;

    // Read-domain control states
    typedef enum logic [1:0] {
        R_RESET = 2'd0,
        R_EMPTY = 2'd1,
        R_VALID = 2'd2
    } rd_state_t;

endpackage

// File: rtl/dcfifo_sync.sv
// Multi-stage synchronizer with asynchronous clear; one flop row per stage.
module dcfifo_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg[0] <= '0;
                else         stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) stg[i] <= '0;
                else         stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcfifo_ram.sv
// Storage array: synchronous write port, combinational read port.
module dcfifo_ram #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 9
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2,
    parameter int DEF_THRESH  = 64
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    input  logic              thr_load,
    input  logic [ADDR_W-1:0] thr_bits,
    input  logic [ADDR_W:0]   rgray_s,
    output logic [ADDR_W:0]   wgray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W-1:0] thresh,
    output logic              in_rdy
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PTR_W-1:0] FULL_MARK = PTR_W'(DEPTH - 1);

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [PTR_W-1:0] b2g(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    wr_state_t        state, state_nx;
    logic             live;
    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] rbin_s;
    logic [PTR_W-1:0] used;
    logic             full;
    logic             req;
    logic             prog_hit;
    logic             data_hit;

    // Reset release synchronizer for the write domain
    dcfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_live (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (1'b1),
        .q      (live)
    );

    assign rbin_s   = g2b(rgray_s);
    assign used     = wbin - rbin_s;
    assign full     = (used == FULL_MARK);
    assign req      = en_hi && !en_lo_n && in_rdy;
    assign prog_hit = req && thr_load && (state == W_PROG);
    assign data_hit = req && !prog_hit;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            W_RESET: state_nx = live ? W_PROG : W_RESET;
            W_PROG:  state_nx = data_hit ? W_RUN : W_PROG;
            W_RUN:   state_nx = W_RUN;
            default: state_nx = W_RESET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= W_RESET;
        else         state <= state_nx;
    end

    // Outputs
    always_comb begin
        in_rdy    = (state != W_RESET) && !full;
        mem_we    = data_hit;
        mem_waddr = wbin[ADDR_W-1:0];
    end

    // Pointer and threshold registers
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            thresh <= ADDR_W'(DEF_THRESH);
        end else begin
            if (data_hit) begin
                wbin  <= wbin + 1'b1;
                wgray <= b2g(wbin + 1'b1);
            end
            if (prog_hit) thresh <= thr_bits;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
        used <= FULL_MARK);                                          // R1
    AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (!arst_n)
        !live |-> !mem_we);                                          // R7
    AST_PROG_NO_STORE: assert property (@(posedge clk) disable iff (!arst_n)
        prog_hit |=> $stable(wbin));                                 // R10
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              arst_n,
    input  logic              rd_en_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [ADDR_W-1:0] thresh,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [DATA_W-1:0] dout,
    output logic              out_rdy,
    output logic              half_full,
    output logic              almost_fe
);
    localparam int PTR_W     = ADDR_W + 1;
    localparam int CNT_W     = PTR_W + 1;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] HALF_MARK = CNT_W'(DEPTH / 2 + 1);
    localparam logic [CNT_W-1:0] TOP_MARK  = CNT_W'(DEPTH);

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    function automatic logic [PTR_W-1:0] b2g(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    rd_state_t        state, state_nx;
    logic             live;
    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] wbin_s;
    logic [PTR_W-1:0] avail;
    logic             ram_has;
    logic             rd_go;
    logic             load;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] thr_w;

    dcfifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_live (
        .clk    (clk),
        .arst_n (arst_n),
        .d      (1'b1),
        .q      (live)
    );

    assign wbin_s  = g2b(wgray_s);
    assign avail   = wbin_s - rbin;
    assign ram_has = (avail != '0);
    assign rd_go   = (state == R_VALID) && !rd_en_n && !oe_a_n && !oe_b_n;
    assign load    = ram_has && ((state == R_EMPTY) || rd_go);
    assign total   = {1'b0, avail} + CNT_W'(state == R_VALID);
    assign thr_w   = CNT_W'(thresh);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            R_RESET: state_nx = live ? R_EMPTY : R_RESET;
            R_EMPTY: state_nx = ram_has ? R_VALID : R_EMPTY;
            R_VALID: state_nx = (rd_go && !ram_has) ? R_EMPTY : R_VALID;
            default: state_nx = R_RESET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= R_RESET;
        else         state <= state_nx;
    end

    // Outputs
    always_comb begin
        out_rdy   = (state == R_VALID);
        mem_raddr = rbin[ADDR_W-1:0];
    end

    // Output register and read pointer
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rbin  <= '0;
            rgray <= '0;
            dout  <= '0;
        end else if (load) begin
            dout  <= mem_rdata;
            rbin  <= rbin + 1'b1;
            rgray <= b2g(rbin + 1'b1);
        end
    end

    // Fill-level flags
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            half_full <= 1'b0;
            almost_fe <= 1'b1;
        end else if (state == R_RESET) begin
            half_full <= 1'b0;
            almost_fe <= 1'b1;
        end else begin
            half_full <= (total >= HALF_MARK);
            almost_fe <= (total <= thr_w) || (total >= TOP_MARK - thr_w);
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
        avail <= PTR_W'(DEPTH - 1));                                 // R1
    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        (out_rdy && !rd_go) |=> (out_rdy && $stable(dout)));         // R3
    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!arst_n)
        (state == R_EMPTY && ram_has) |=> out_rdy);                  // R4
    AST_LAST_READ: assert property (@(posedge clk) disable iff (!arst_n)
        (rd_go && !ram_has) |=> !out_rdy);                           // R5
    AST_RESET_FLAGS: assert property (@(posedge clk) disable iff (!arst_n)
        (state == R_RESET) |-> (!out_rdy && !half_full && almost_fe)); // R6
endmodule

// File: rtl/dcfifo_fwft.sv
module dcfifo_fwft #(
    parameter int DATA_W      = 18,
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2,
    parameter int DEF_THRESH  = 64
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_en_hi,
    input  logic              wr_en_lo_n,
    input  logic              thr_load,
    input  logic [DATA_W-1:0] din,
    output logic              in_rdy,
    input  logic              rd_en_n,
    input  logic              oe_a_n,
    input  logic              oe_b_n,
    output logic [DATA_W-1:0] dout,
    output logic              out_rdy,
    output logic              half_full,
    output logic              almost_fe
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr, thresh;
    logic [DATA_W-1:0] mem_rdata;

    dcfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk    (rd_clk),
        .arst_n (rst_n),
        .d      (wgray),
        .q      (wgray_s)
    );

    dcfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk    (wr_clk),
        .arst_n (rst_n),
        .d      (rgray),
        .q      (rgray_s)
    );

    dcfifo_wr_ctrl #(
        .ADDR_W      (ADDR_W),
        .SYNC_STAGES (SYNC_STAGES),
        .DEF_THRESH  (DEF_THRESH)
    ) u_wr (
        .clk       (wr_clk),
        .arst_n    (rst_n),
        .en_hi     (wr_en_hi),
        .en_lo_n   (wr_en_lo_n),
        .thr_load  (thr_load),
        .thr_bits  (din[ADDR_W-1:0]),
        .rgray_s   (rgray_s),
        .wgray     (wgray),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .thresh    (thresh),
        .in_rdy    (in_rdy)
    );

    dcfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (din),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dcfifo_rd_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rd (
        .clk       (rd_clk),
        .arst_n    (rst_n),
        .rd_en_n   (rd_en_n),
        .oe_a_n    (oe_a_n),
        .oe_b_n    (oe_b_n),
        .wgray_s   (wgray_s),
        .thresh    (thresh),
        .mem_rdata (mem_rdata),
        .rgray     (rgray),
        .mem_raddr (mem_raddr),
        .dout      (dout),
        .out_rdy   (out_rdy),
        .half_full (half_full),
        .almost_fe (almost_fe)
    );
endmodule

// File: tb/tb_dcfifo_fwft.sv
module tb_dcfifo_fwft;
    localparam int DW    = 18;
    localparam int DEPTH = 512;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          wr_en_hi = 1'b0, wr_en_lo_n = 1'b1, thr_load = 1'b0;
    logic [DW-1:0] din = '0;
    logic          rd_en_n = 1'b1, oe_a_n = 1'b1, oe_b_n = 1'b1;
    logic          in_rdy, out_rdy, half_full, almost_fe;
    logic [DW-1:0] dout;

    dcfifo_fwft dut (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
        .wr_en_hi(wr_en_hi), .wr_en_lo_n(wr_en_lo_n), .thr_load(thr_load),
        .din(din), .in_rdy(in_rdy),
        .rd_en_n(rd_en_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .dout(dout), .out_rdy(out_rdy),
        .half_full(half_full), .almost_fe(almost_fe)
    );

    int            n_cmp = 0;
    int            n_bad = 0;
    logic [DW-1:0] q[$];
    bit            prog_open = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One cycle: compare at the falling edge, then drive and update the model
    task automatic step(input logic wh, input logic wl_n, input logic tl,
                        input logic [DW-1:0] d, input logic re_n,
                        input logic oa_n, input logic ob_n);
        @(negedge clk);
        if (out_rdy) begin
            if (q.size() == 0) chk(1'b0, "R5", "out_rdy with nothing stored", 1, 0);
            else chk(dout == q[0], "R3", "dout vs oldest word", int'(dout), int'(q[0]));
        end
        if (in_rdy) chk(q.size() < DEPTH, "R1", "in_rdy while 512 held", q.size(), DEPTH - 1);
        wr_en_hi = wh; wr_en_lo_n = wl_n; thr_load = tl; din = d;
        rd_en_n = re_n; oe_a_n = oa_n; oe_b_n = ob_n;
        if (out_rdy && !re_n && !oa_n && !ob_n && rst_n) void'(q.pop_front());
        if (wh && !wl_n && in_rdy && rst_n) begin
            if (prog_open && tl) begin
                // threshold load, nothing stored
            end else begin
                q.push_back(d);
                prog_open = 1'b0;
            end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) step(1'b0, 1'b1, 1'b0, '0, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic wr_word(input logic [DW-1:0] d, input logic tl);
        step(1'b1, 1'b0, tl, d, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic drain_to(input int n);
        int guard = 0;
        while (q.size() > n && guard < 5000) begin
            step(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
            guard++;
        end
        step(1'b0, 1'b1, 1'b0, '0, 1'b1, 1'b1, 1'b1);
        idle(8);
    endtask

    task automatic wait_in_rdy();
        int guard = 0;
        while (!in_rdy && guard < 50) begin
            idle(1);
            guard++;
        end
    endtask

    task automatic reset_phase();
        @(negedge clk);
        rst_n = 1'b0;
        q.delete();
        // writes attempted during reset
        repeat (6) step(1'b1, 1'b0, 1'b0, 18'd999, 1'b0, 1'b0, 1'b0);
        chk(in_rdy == 1'b0, "R6", "in_rdy in reset", in_rdy, 0);
        chk(out_rdy == 1'b0, "R6", "out_rdy in reset", out_rdy, 0);
        chk(half_full == 1'b0, "R6", "half_full in reset", half_full, 0);
        chk(almost_fe == 1'b1, "R6", "almost_fe in reset", almost_fe, 1);
        rst_n = 1'b1;
        prog_open = 1'b1;
        step(1'b1, 1'b0, 1'b0, 18'd998, 1'b1, 1'b1, 1'b1);
        chk(in_rdy == 1'b0, "R7", "in_rdy one edge after release", in_rdy, 0);
        step(1'b1, 1'b0, 1'b0, 18'd997, 1'b1, 1'b1, 1'b1);
        chk(in_rdy == 1'b0, "R7", "in_rdy two edges after release", in_rdy, 0);
        idle(8);
        chk(out_rdy == 1'b0, "R7", "no word from writes near reset", out_rdy, 0);
        wait_in_rdy();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        reset_phase();

        // R10: program N = 8 while in the programming window
        wr_word(18'd8, 1'b1);
        idle(8);
        chk(out_rdy == 1'b0, "R10", "threshold load stored nothing", out_rdy, 0);
        chk(almost_fe == 1'b1, "R9", "almost_fe at count 0", almost_fe, 1);

        // R4: fall-through with read enable low but a qualifier high
        for (int i = 0; i < 8; i++)
            step(1'b1, 1'b0, 1'b0, 18'(100 + i), 1'b0, 1'b1, 1'b0);
        idle(8);
        chk(out_rdy == 1'b1, "R4", "out_rdy after first words", out_rdy, 1);
        chk(dout == 18'd100, "R4", "first word fell through", int'(dout), 100);
        chk(almost_fe == 1'b1, "R9", "almost_fe at count 8, N=8", almost_fe, 1);
        chk(half_full == 1'b0, "R8", "half_full at count 8", half_full, 0);

        // R10: thr_load in run state stores data
        wr_word(18'd200, 1'b1);
        idle(8);
        chk(almost_fe == 1'b0, "R10", "thr_load word counted, count 9", almost_fe, 0);

        // R2: writes with either enable inactive
        step(1'b0, 1'b0, 1'b0, 18'd7777, 1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0, 18'd7778, 1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b0, 18'd7779, 1'b1, 1'b1, 1'b1);
        idle(8);
        chk(almost_fe == 1'b0, "R2", "count unchanged by disabled writes", almost_fe, 0);

        // R3: each qualifier alone blocks the read
        step(1'b0, 1'b1, 1'b0, '0, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b1);
        idle(2);
        chk(dout == 18'd100, "R3", "dout held under blocked reads", int'(dout), 100);

        drain_to(0);
        chk(out_rdy == 1'b0, "R2", "nothing left after nine reads", out_rdy, 0);
        chk(out_rdy == 1'b0, "R5", "out_rdy falls after last read", out_rdy, 0);

        // R1: fill with reads blocked
        for (int i = 0; i < 600; i++) wr_word(18'(1000 + i), 1'b0);
        idle(8);
        chk(q.size() == DEPTH, "R1", "words accepted with no reads", q.size(), DEPTH);
        chk(in_rdy == 1'b0, "R1", "in_rdy when full", in_rdy, 0);
        chk(half_full == 1'b1, "R8", "half_full at 512", half_full, 1);
        chk(almost_fe == 1'b1, "R9", "almost_fe at 512", almost_fe, 1);

        drain_to(504);
        chk(almost_fe == 1'b1, "R9", "almost_fe at 504, N=8", almost_fe, 1);
        drain_to(503);
        chk(almost_fe == 1'b0, "R9", "almost_fe at 503", almost_fe, 0);
        drain_to(257);
        chk(half_full == 1'b1, "R8", "half_full at 257", half_full, 1);
        drain_to(256);
        chk(half_full == 1'b0, "R8", "half_full at 256", half_full, 0);
        drain_to(9);
        chk(almost_fe == 1'b0, "R9", "almost_fe at 9", almost_fe, 0);
        drain_to(8);
        chk(almost_fe == 1'b1, "R9", "almost_fe at 8", almost_fe, 1);

        // Mixed traffic with random qualifiers
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r[0], r[1] & r[2], 1'b0, 18'($urandom),
                 r[3] & r[1], 1'b0, r[2] & r[3]);
        end
        drain_to(0);
        chk(out_rdy == 1'b0, "R5", "empty after mixed traffic", out_rdy, 0);
        chk(in_rdy == 1'b1, "R1", "in_rdy when empty", in_rdy, 1);

        // Mid-run reset restores the default threshold
        for (int i = 0; i < 20; i++) wr_word(18'(3000 + i), 1'b0);
        reset_phase();
        for (int i = 0; i < 64; i++) wr_word(18'(5000 + i), 1'b0);
        idle(8);
        chk(dout == 18'd5000, "R4", "first word after reset", int'(dout), 5000);
        chk(almost_fe == 1'b1, "R9", "default N=64 at count 64", almost_fe, 1);
        wr_word(18'd5064, 1'b0);
        idle(8);
        chk(almost_fe == 1'b0, "R9", "default N=64 at count 65", almost_fe, 0);
        drain_to(0);

        finish_run();
    end
endmodule